// File: doc/BRIEF.md
# Landing-Pad Expectation Save/Restore Unit

This block keeps the single bit that records whether the next fetched instruction must be a landing pad, together with the two copies of it that trap entry saves: one slot for traps handled in machine mode and one for traps handled in supervisor mode. It also picks which landing-pad enable applies, based on the current privilege and on whether the hart implements supervisor mode. The pipeline drives it with plain control pulses: a trap with its target privilege, a machine or supervisor trap return with the privilege being returned to, and set and clear requests from the landing-pad checker.

On a trap, the expectation bit is copied into the slot of the handling privilege and then cleared. On a trap return, the bit is restored from that slot only when landing pads are enabled for the privilege being returned to, and the slot is emptied afterwards. The saved bits are presented at their places in the machine status word, so the CSR file can merge them in directly. For a 32-bit hart the machine slot appears in the upper status half. All pins are level or single-cycle control signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `elp_save_restore`

## Requirements
- R1: After reset the expectation bit and both saved slots read 0, where 1 means a landing pad is expected and 0 means none.
- R2: `lp_enable` follows the current privilege, encoded 2'b11 machine, 2'b01 supervisor, 2'b00 user and 2'b10 reserved. Machine selects `en_mach` and supervisor selects `en_menv`. User selects `en_senv` when `smode_present` is 1 and `en_menv` when it is 0. Reserved gives 0.
- R3: With no trap and no return, `lp_clear` clears the bit. `lp_set` sets it only when `lp_enable` is 1 and has no effect otherwise. When both are requested, clear wins.
- R4: A trap whose target is machine (2'b11), or any trap when `smode_present` is 0, copies the bit into the machine slot and clears the bit on the next edge.
- R5: A trap with a non-machine target and `smode_present` 1 copies the bit into the supervisor slot and clears the bit. The machine slot is left unchanged.
- R6: A trap takes priority over `lp_set` and `lp_clear` in the same cycle, and the saved value is the bit as it stood before that cycle.
- R7: A machine return with no trap loads the bit from the machine slot if the enable selected for `ret_priv` (same rule as R2) is 1, and loads 0 otherwise. It always clears the machine slot.
- R8: A supervisor return without a trap or machine return does the same using the supervisor slot, which it clears.
- R9: A machine return and a supervisor return in the same cycle act as a machine return alone, and the supervisor slot keeps its value.
- R10: `stat_lo` carries the supervisor slot at bit 23. The machine slot sits at bit 41 of the 64-bit status view: `stat_lo[41]` when XLEN is 64, or `stat_hi[9]` when XLEN is 32. Every other bit of both words is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_priv | input | 2 | Current privilege level |
| smode_present | input | 1 | Hart implements supervisor mode |
| en_mach | input | 1 | Machine landing-pad enable |
| en_menv | input | 1 | Enable set in the machine environment configuration |
| en_senv | input | 1 | Enable set in the supervisor environment configuration |
| trap_take | input | 1 | Trap taken this cycle |
| trap_priv | input | 2 | Privilege that handles the trap |
| mret | input | 1 | Machine trap return this cycle |
| sret | input | 1 | Supervisor trap return this cycle |
| ret_priv | input | 2 | Privilege being returned to |
| lp_set | input | 1 | Checker requests expectation set |
| lp_clear | input | 1 | Checker requests expectation clear |
| elp | output | 1 | Current landing-pad expectation |
| stat_lo | output | XLEN | Status word bits holding saved slots |
| stat_hi | output | 32 | Upper status half (machine slot when XLEN is 32) |
| lp_enable | output | 1 | Enable selected for the current privilege |

## Verification
The bench builds two copies side by side, one with XLEN 64 and one with XLEN 32, and drives both with the same stimulus. This lets one run confirm that the machine slot lands at bit 41 of the low word in the wide build and at bit 9 of the high word in the narrow one. `smode_present` is an input, so the user-mode enable fallback and the redirection of supervisor-target traps into the machine slot are both reached without a second build.

// File: rtl/elp_pkg.sv
package elp_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_TRAP_M,
    EV_TRAP_S,
    EV_MRET,
    EV_SRET,
    EV_CLEAR,
    EV_SET
  } elp_ev_e;

  localparam int unsigned MPELP_POS = 41;
  localparam int unsigned SPELP_POS = 23;
endpackage

// File: rtl/elp_en_select.sv
module elp_en_select
  import elp_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       smode_present,
  input  logic       en_mach,
  input  logic       en_menv,
  input  logic       en_senv,
  output logic       en
);
  always_comb begin
    unique case (priv_e'(priv))
      PRIV_M:  en = en_mach;
      PRIV_S:  en = en_menv;
      PRIV_U:  en = smode_present ? en_senv : en_menv;
      default: en = 1'b0;
    endcase
  end
endmodule

// File: rtl/elp_event_arb.sv
module elp_event_arb
  import elp_pkg::*;
(
  input  logic       trap_take,
  input  logic [1:0] trap_priv,
  input  logic       smode_present,
  input  logic       mret,
  input  logic       sret,
  input  logic       lp_set,
  input  logic       lp_clear,
  input  logic       en_cur,
  output elp_ev_e    ev
);
  logic to_mach;
  assign to_mach = (priv_e'(trap_priv) == PRIV_M) || !smode_present;

  always_comb begin
    if (trap_take)             ev = to_mach ? EV_TRAP_M : EV_TRAP_S;
    else if (mret)             ev = EV_MRET;
    else if (sret)             ev = EV_SRET;
    else if (lp_clear)         ev = EV_CLEAR;
    else if (lp_set && en_cur) ev = EV_SET;
    else                       ev = EV_NONE;
  end
endmodule

// File: rtl/elp_state_reg.sv
module elp_state_reg
  import elp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  elp_ev_e ev,
  input  logic    ret_en,
  output logic    elp,
  output logic    mpelp,
  output logic    spelp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elp   <= 1'b0;
      mpelp <= 1'b0;
      spelp <= 1'b0;
    end else begin
      unique case (ev)
        EV_TRAP_M: begin mpelp <= elp; elp <= 1'b0; end
        EV_TRAP_S: begin spelp <= elp; elp <= 1'b0; end
        EV_MRET:   begin elp <= ret_en & mpelp; mpelp <= 1'b0; end
        EV_SRET:   begin elp <= ret_en & spelp; spelp <= 1'b0; end
        EV_CLEAR:  elp <= 1'b0;
        EV_SET:    elp <= 1'b1;
        default:   ;
      endcase
    end
  end

  assert_trap_m_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TRAP_M) |=> (mpelp == $past(elp)) && !elp);
  assert_trap_s_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TRAP_S) |=> (spelp == $past(elp)) && !elp && $stable(mpelp));
  assert_mret_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_MRET) |=> !mpelp && (elp == ($past(ret_en) && $past(mpelp))));
  assert_sret_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_SRET) |=> !spelp && (elp == ($past(ret_en) && $past(spelp))));
endmodule

// File: rtl/elp_status_map.sv
module elp_status_map
  import elp_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            mpelp,
  input  logic            spelp,
  output logic [XLEN-1:0] stat_lo,
  output logic [31:0]     stat_hi
);
  localparam int unsigned HI_POS = MPELP_POS - 32;

  generate
    if (XLEN == 64) begin : g_wide
      always_comb begin
        stat_lo            = '0;
        stat_lo[SPELP_POS] = spelp;
        stat_lo[MPELP_POS] = mpelp;
        stat_hi            = '0;
      end
    end else begin : g_narrow
      always_comb begin
        stat_lo            = '0;
        stat_lo[SPELP_POS] = spelp;
        stat_hi            = '0;
        stat_hi[HI_POS]    = mpelp;
      end
    end
  endgenerate
endmodule

// File: rtl/elp_save_restore.sv
module elp_save_restore
  import elp_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cur_priv,
  input  logic            smode_present,
  input  logic            en_mach,
  input  logic            en_menv,
  input  logic            en_senv,
  input  logic            trap_take,
  input  logic [1:0]      trap_priv,
  input  logic            mret,
  input  logic            sret,
  input  logic [1:0]      ret_priv,
  input  logic            lp_set,
  input  logic            lp_clear,
  output logic            elp,
  output logic [XLEN-1:0] stat_lo,
  output logic [31:0]     stat_hi,
  output logic            lp_enable
);
  localparam int unsigned NSEL = 2;

  logic [1:0]      sel_priv [NSEL];
  logic [NSEL-1:0] sel_en;
  elp_ev_e         ev;
  logic            mpelp, spelp;

  assign sel_priv[0] = cur_priv;
  assign sel_priv[1] = ret_priv;

  generate
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
      elp_en_select u_sel (
        .priv          (sel_priv[g]),
        .smode_present (smode_present),
        .en_mach       (en_mach),
        .en_menv       (en_menv),
        .en_senv       (en_senv),
        .en            (sel_en[g])
      );
    end
  endgenerate

  assign lp_enable = sel_en[0];

  elp_event_arb u_arb (
    .trap_take     (trap_take),
    .trap_priv     (trap_priv),
    .smode_present (smode_present),
    .mret          (mret),
    .sret          (sret),
    .lp_set        (lp_set),
    .lp_clear      (lp_clear),
    .en_cur        (sel_en[0]),
    .ev            (ev)
  );

  elp_state_reg u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .ret_en (sel_en[1]),
    .elp    (elp),
    .mpelp  (mpelp),
    .spelp  (spelp)
  );

  elp_status_map #(.XLEN(XLEN)) u_map (
    .mpelp   (mpelp),
    .spelp   (spelp),
    .stat_lo (stat_lo),
    .stat_hi (stat_hi)
  );

  assert_reserved_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == 2'b10) |-> !lp_enable);
  assert_set_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!elp && !lp_enable && !trap_take && !mret && !sret) |=> !elp);
  assert_trap_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && (lp_set || lp_clear)) |=> !elp);
  assert_mret_over_sret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && sret && !trap_take) |=> $stable(spelp));
endmodule

// File: tb/elp_save_restore_bench.sv
module elp_save_restore_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] cur_priv = 2'b11, trap_priv = 2'b11, ret_priv = 2'b00;
  logic smode_present = 1'b1, en_mach = 1'b0, en_menv = 1'b0, en_senv = 1'b0;
  logic trap_take = 1'b0, mret = 1'b0, sret = 1'b0, lp_set = 1'b0, lp_clear = 1'b0;

  logic        elp_a, en_a, elp_b, en_b;
  logic [63:0] lo_a;
  logic [31:0] hi_a, lo_b, hi_b;

  elp_save_restore #(.XLEN(64)) u_elp_save_restore (
    .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .smode_present(smode_present),
    .en_mach(en_mach), .en_menv(en_menv), .en_senv(en_senv), .trap_take(trap_take),
    .trap_priv(trap_priv), .mret(mret), .sret(sret), .ret_priv(ret_priv),
    .lp_set(lp_set), .lp_clear(lp_clear), .elp(elp_a), .stat_lo(lo_a),
    .stat_hi(hi_a), .lp_enable(en_a));

  elp_save_restore #(.XLEN(32)) u_elp_save_restore_32 (
    .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .smode_present(smode_present),
    .en_mach(en_mach), .en_menv(en_menv), .en_senv(en_senv), .trap_take(trap_take),
    .trap_priv(trap_priv), .mret(mret), .sret(sret), .ret_priv(ret_priv),
    .lp_set(lp_set), .lp_clear(lp_clear), .elp(elp_b), .stat_lo(lo_b),
    .stat_hi(hi_b), .lp_enable(en_b));

  int vectors = 0, errors = 0;
  int m_elp = 0, m_mp = 0, m_sp = 0;
  bit done = 0;

  function automatic int en_of(logic [1:0] p);
    case (p)
      2'b11: return int'(en_mach);
      2'b01: return int'(en_menv);
      2'b00: return smode_present ? int'(en_senv) : int'(en_menv);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk(tag, longint'(elp_a), longint'(m_elp));
    chk(tag, longint'(elp_b), longint'(m_elp));
    chk("R10", longint'(lo_a), (longint'(m_mp) << 41) | (longint'(m_sp) << 23));
    chk("R10", longint'(hi_a), 0);
    chk("R10", longint'(lo_b), longint'(m_sp) << 23);
    chk("R10", longint'(hi_b), longint'(m_mp) << 9);
  endtask

  // inputs are set at a negedge; the step samples combinational enable, clocks, then compares state
  task automatic tick();
    int n_elp, n_mp, n_sp;
    string tag;
    #1;
    chk("R2", longint'(en_a), longint'(en_of(cur_priv)));
    chk("R2", longint'(en_b), longint'(en_of(cur_priv)));
    n_elp = m_elp; n_mp = m_mp; n_sp = m_sp; tag = "R3";
    if (trap_take) begin
      if (trap_priv == 2'b11 || !smode_present) begin n_mp = m_elp; tag = "R4"; end
      else begin n_sp = m_elp; tag = "R5"; end
      n_elp = 0;
      if (lp_set || lp_clear) tag = "R6";
    end else if (mret) begin
      n_elp = (en_of(ret_priv) != 0) ? m_mp : 0; n_mp = 0;
      tag = sret ? "R9" : "R7";
    end else if (sret) begin
      n_elp = (en_of(ret_priv) != 0) ? m_sp : 0; n_sp = 0; tag = "R8";
    end else if (lp_clear) n_elp = 0;
    else if (lp_set && en_of(cur_priv) != 0) n_elp = 1;
    @(posedge clk);
    m_elp = n_elp; m_mp = n_mp; m_sp = n_sp;
    @(negedge clk);
    chk_state(tag);
  endtask

  task automatic idle();
    trap_take = 0; mret = 0; sret = 0; lp_set = 0; lp_clear = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1");

    // R2: walk every privilege, S presence and enable combination
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 8; e++) begin
          cur_priv = 2'(p); smode_present = s[0];
          {en_mach, en_menv, en_senv} = 3'(e);
          tick();
        end

    // R3: set is ignored while disabled, honoured when enabled, clear beats set
    smode_present = 1; cur_priv = 2'b11; en_mach = 0; en_menv = 1; en_senv = 1;
    lp_set = 1; tick();
    en_mach = 1; tick();
    lp_clear = 1; tick();
    idle(); lp_set = 1; tick(); idle();

    // R4 then R7: save to machine slot, restore to user with enable on
    trap_take = 1; trap_priv = 2'b11; tick(); idle();
    mret = 1; ret_priv = 2'b00; tick(); idle();
    // R5 then R8: save to supervisor slot, return with enable off gives 0
    trap_take = 1; trap_priv = 2'b01; tick(); idle();
    en_senv = 0; sret = 1; ret_priv = 2'b00; tick(); idle();
    // R5 with S absent redirects into machine slot
    en_senv = 1; lp_set = 1; tick(); idle();
    smode_present = 0; trap_take = 1; trap_priv = 2'b01; tick(); idle();
    smode_present = 1;
    // R6: trap together with set saves the pre-set value
    trap_take = 1; trap_priv = 2'b11; lp_set = 1; tick(); idle();
    // R9: both returns in one cycle
    lp_set = 1; tick(); idle();
    trap_take = 1; trap_priv = 2'b01; tick(); idle();
    lp_set = 1; tick(); idle();
    trap_take = 1; trap_priv = 2'b11; tick(); idle();
    mret = 1; sret = 1; ret_priv = 2'b11; tick(); idle();
    sret = 1; ret_priv = 2'b01; tick(); idle();

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cur_priv = r[1:0]; trap_priv = r[3:2]; ret_priv = r[5:4];
      smode_present = (r[7:6] != 2'b00);
      {en_mach, en_menv, en_senv} = r[10:8];
      trap_take = (r[14:11] == 4'd0);
      mret = (r[17:15] == 3'd0);
      sret = (r[20:18] == 3'd0);
      lp_set = r[21] & r[22];
      lp_clear = (r[25:23] == 3'd0);
      tick();
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule